// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a single start strobe into the run of column addresses that one memory burst walks through. The inputs are a start column, a burst-length code and an ordering bit. On each clock of the burst the block presents one column, flags it as a valid beat, and marks the final beat. The address bits inside the burst-sized block either count upward and wrap inside that block (sequential order), or are the start bits XORed with the beat number (interleaved order). The bits above the block never change during the burst.

A full-page length walks the whole row and does not end by itself. It wraps from the top column back to column zero and keeps going until a stop strobe ends it. A single-beat write mode cuts write bursts to one beat and leaves reads at their programmed length. An unsupported setting gives a one-beat burst and raises an error flag. A new start strobe always restarts the generator at once with the new settings, even in the middle of a burst.

The controller sits in one of three named states. ST_IDLE means no burst is running. ST_BURST means a fixed-length burst is running. ST_PAGE means a full-page burst is running. The transitions are:
- START: a start strobe, taken in any state, leads to ST_PAGE for a full-page setting and to ST_BURST for any other setting.
- FINISH: in ST_BURST, the last beat leads to ST_IDLE.
- STOP: a stop strobe in ST_BURST or ST_PAGE leads to ST_IDLE.
- ADVANCE: in any other case a running burst keeps its state and moves to the next beat.

Top module: `burst_col_gen`

## Requirements
- R1: The length code gives the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. `last_o` is high on the final beat only, and `beat_vld_o` is low on the cycle after that beat unless a new start is sampled.
- R2: With `interleave_i`=0 the low log2(L) bits of beat i equal (start + i) mod L, where L is the burst length. For example, start 5 with length 8 gives 5,6,7,0,1,2,3,4.
- R3: With `interleave_i`=1 the low log2(L) bits of beat i equal start XOR i. For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R4: The column bits above the burst-sized block equal those of the start column on every beat of the burst.
- R5: Code 3'b111 with sequential order selects full page. Beat i is (start + i) mod 256. The burst passes 256 beats without ending, and `last_o` stays low.
- R6: With `single_wr_i`=1 and `write_i`=1 the burst is exactly one beat. Reads, and writes made with `single_wr_i`=0, keep the programmed length.
- R7: When `stop_i` is high on a cycle where `beat_vld_o` is high, the beat on that cycle is the final one. `stop_i` has no effect while the block is idle.
- R8: The codes 3'b100, 3'b101 and 3'b110, and also 3'b111 with interleaved order, give a one-beat burst at the start column. They set `cfg_err_o`, which stays high until the next start. A valid setting clears it.
- R9: A start strobe sampled during a burst restarts the burst with the new settings on the next cycle. A start strobe takes priority over a stop strobe on the same cycle.
- R10: After reset, `beat_vld_o`, `last_o` and `cfg_err_o` are 0 and `col_o` is 0.
- R11: The first beat, with `col_o` equal to the start column, appears on the cycle after the edge that samples `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a burst; the other inputs are sampled with it |
| start_col_i | input | 8 | Start column |
| len_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 1 selects interleaved order, 0 selects sequential order |
| single_wr_i | input | 1 | Single-beat write mode |
| write_i | input | 1 | The burst is a write |
| stop_i | input | 1 | Ends the running burst after the current beat |
| col_o | output | 8 | Column of the current beat (0 when idle) |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | The current beat is the final one |
| cfg_err_o | output | 1 | The last start used an unsupported setting |

## Verification
The main function is driven by a fixed-seed random mix of start columns, every length code, both orderings, and both read and write under both single-beat modes. Random stop points are added, so normal completion and early termination are both covered. Directed cases use start 5 at length 8 in both orders. This separates carry-wrap inside the block from XOR ordering, which agree at start 0. A full-page run past 256 beats shows both the wrap to column zero and the absence of any self-ending. A mid-burst restart that also asserts stop separates start priority from stop handling, and a stop while idle shows that stop has no effect with no burst running.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code_i,
    input  logic             itl_i,
    input  logic             swr_i,
    input  logic             wr_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o,
    output logic             err_o
);
    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        err_o  = 1'b0;
        unique case (code_i)
            3'b000: mask_o = '0;
            3'b001: mask_o = COL_W'(1);
            3'b010: mask_o = COL_W'(3);
            3'b011: mask_o = COL_W'(7);
            3'b111: begin
                if (itl_i) begin
                    err_o = 1'b1;
                end else begin
                    page_o = 1'b1;
                    mask_o = '1;
                end
            end
            default: err_o = 1'b1;
        endcase
        if (swr_i && wr_i) begin
            mask_o = '0;
            page_o = 1'b0;
        end
    end
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             itl_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] xor_low;

    always_comb begin
        seq_low = (base_i + cnt_i) & mask_i;
        xor_low = (base_i ^ cnt_i) & mask_i;
        col_o   = (base_i & ~mask_i) | (itl_i ? xor_low : seq_low);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             single_wr_i,
    input  logic             write_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_o,
    output logic             cfg_err_o
);
    bcg_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, cnt_q, mask_q;
    logic             itl_q, err_q;
    logic [COL_W-1:0] mask_d;
    logic             page_d, err_d;
    logic [COL_W-1:0] col_calc;
    logic             at_end;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (len_code_i),
        .itl_i  (interleave_i),
        .swr_i  (single_wr_i),
        .wr_i   (write_i),
        .mask_o (mask_d),
        .page_o (page_d),
        .err_o  (err_d)
    );

    bcg_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_i (base_q),
        .cnt_i  (cnt_q),
        .mask_i (mask_q),
        .itl_i  (itl_q),
        .col_o  (col_calc)
    );

    assign at_end = (cnt_q == mask_q);

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = page_d ? ST_PAGE : ST_BURST;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BURST: if (stop_i || at_end) state_d = ST_IDLE;
                ST_PAGE:  if (stop_i) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst parameters and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            mask_q <= '0;
            itl_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (start_i) begin
            base_q <= start_col_i;
            cnt_q  <= '0;
            mask_q <= mask_d;
            itl_q  <= interleave_i;
            err_q  <= err_d;
        end else if (state_q != ST_IDLE) begin
            cnt_q  <= cnt_q + COL_W'(1);
        end
    end

    // outputs
    always_comb begin
        beat_vld_o = (state_q != ST_IDLE);
        last_o     = (state_q == ST_BURST) && at_end;
        col_o      = beat_vld_o ? col_calc : '0;
        cfg_err_o  = err_q;
    end

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_vld_o); // R1
    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !beat_vld_o); // R1
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && stop_i && !start_i) |=> !beat_vld_o); // R7
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_vld_o && !start_i) |=> !beat_vld_o); // R7
    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_vld_o && col_o == $past(start_col_i))); // R11
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !start_i) |=> (!beat_vld_o || ((col_o & ~mask_q) == $past(col_o & ~mask_q)))); // R4
    AST_ERR_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_o && beat_vld_o) |-> last_o); // R8
    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE) |-> !last_o); // R5
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       single_wr_i = 1'b0;
    logic       write_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_vld_o, last_o, cfg_err_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    burst_col_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .interleave_i(interleave_i), .single_wr_i(single_wr_i),
        .write_i(write_i), .stop_i(stop_i), .col_o(col_o), .beat_vld_o(beat_vld_o),
        .last_o(last_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_err(input logic [2:0] code, input bit itl);
        return (code inside {3'b100, 3'b101, 3'b110}) || (code == 3'b111 && itl);
    endfunction

    function automatic bit is_page(input logic [2:0] code, input bit itl, input bit swr, input bit wr);
        return code == 3'b111 && !itl && !(swr && wr);
    endfunction

    function automatic int exp_len(input logic [2:0] code, input bit itl, input bit swr, input bit wr);
        if (swr && wr) return 1;
        if (is_err(code, itl)) return 1;
        case (code)
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int st, input int len, input bit itl, input int i);
        int m;
        m = len - 1;
        if (itl) return (st & ~m & 255) | ((st ^ i) & m);
        return (st & ~m & 255) | ((st + i) & m);
    endfunction

    task automatic launch(input int st, input logic [2:0] code, input bit itl,
                          input bit swr, input bit wr);
        start_col_i  = 8'(st);
        len_code_i   = code;
        interleave_i = itl;
        single_wr_i  = swr;
        write_i      = wr;
        start_i      = 1'b1;
        @(negedge clk);
        start_i      = 1'b0;
        stop_i       = 1'b0;
    endtask

    // beat 0 is visible on entry; stop_at < 0 means no stop
    task automatic check_beats(input int st, input logic [2:0] code, input bit itl,
                               input bit swr, input bit wr, input int stop_at);
        int  len;
        bit  page, err;
        int  nb;
        len  = exp_len(code, itl, swr, wr);
        page = is_page(code, itl, swr, wr);
        err  = is_err(code, itl);
        nb   = len;
        if (stop_at >= 0 && stop_at + 1 < nb) nb = stop_at + 1;
        if (page && stop_at >= 0) nb = stop_at + 1;
        for (int i = 0; i < nb; i++) begin
            chk(beat_vld_o == 1'b1, "R1 beat valid", int'(beat_vld_o), 1);
            if (itl) chk(col_o == 8'(exp_col(st, len, itl, i)), "R3 interleaved column", int'(col_o), exp_col(st, len, itl, i));
            else     chk(col_o == 8'(exp_col(st, len, itl, i)), "R2 sequential column", int'(col_o), exp_col(st, len, itl, i));
            chk(last_o == (!page && i == len - 1), "R1 last flag", int'(last_o), int'(!page && i == len - 1));
            chk(cfg_err_o == err, "R8 error flag", int'(cfg_err_o), int'(err));
            if (i == stop_at) stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
        end
        chk(beat_vld_o == 1'b0, "R7 burst ended", int'(beat_vld_o), 0);
        chk(cfg_err_o == err, "R8 error flag held", int'(cfg_err_o), int'(err));
    endtask

    task automatic run(input int st, input logic [2:0] code, input bit itl,
                       input bit swr, input bit wr, input int stop_at);
        launch(st, code, itl, swr, wr);
        check_beats(st, code, itl, swr, wr, stop_at);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(beat_vld_o == 0 && last_o == 0 && cfg_err_o == 0 && col_o == 0,
            "R10 reset state", int'(beat_vld_o) + int'(last_o) + int'(cfg_err_o) + int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3 directed examples
        run(5, 3'b011, 1'b0, 1'b0, 1'b0, -1);
        run(5, 3'b011, 1'b1, 1'b0, 1'b0, -1);
        // R4 upper bits with short bursts
        run(8'hB7, 3'b010, 1'b0, 1'b0, 1'b0, -1);
        run(8'hB7, 3'b001, 1'b1, 1'b0, 1'b0, -1);
        run(8'h4A, 3'b000, 1'b0, 1'b0, 1'b0, -1);
        // R5 full page past 256 beats
        run(8'hFD, 3'b111, 1'b0, 1'b0, 1'b0, 270);
        // R6 single-beat write, read keeps length, mode off keeps length
        run(3, 3'b011, 1'b0, 1'b1, 1'b1, -1);
        run(3, 3'b011, 1'b0, 1'b1, 1'b0, -1);
        run(3, 3'b011, 1'b0, 1'b0, 1'b1, -1);
        run(3, 3'b111, 1'b0, 1'b1, 1'b1, -1);
        // R8 reserved codes and interleaved full page
        run(9, 3'b101, 1'b0, 1'b0, 1'b0, -1);
        run(9, 3'b111, 1'b1, 1'b0, 1'b0, -1);
        // R7 stop while idle: no burst, error flag unchanged
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(beat_vld_o == 1'b0, "R7 idle stop ignored", int'(beat_vld_o), 0);
        chk(cfg_err_o == 1'b1, "R7 idle stop keeps error", int'(cfg_err_o), 1);
        run(9, 3'b010, 1'b0, 1'b0, 1'b0, -1);   // R8 cleared by valid start
        // R7 stop mid-burst
        run(2, 3'b011, 1'b1, 1'b0, 1'b0, 2);

        // R9 restart mid-burst, start wins over stop
        launch(8'h10, 3'b011, 1'b0, 1'b0, 1'b0);
        chk(col_o == 8'h10, "R11 first beat", int'(col_o), 16);
        @(negedge clk);
        chk(col_o == 8'h11, "R9 before restart", int'(col_o), 17);
        stop_i = 1'b1;
        launch(8'h26, 3'b010, 1'b1, 1'b0, 1'b0);
        check_beats(8'h26, 3'b010, 1'b1, 1'b0, 1'b0, -1);   // R9

        // random mix
        for (int k = 0; k < 150; k++) begin
            int st, sa;
            logic [2:0] code;
            bit itl, swr, wr;
            st   = int'($urandom % 256);
            code = 3'($urandom % 8);
            itl  = 1'($urandom % 2);
            swr  = 1'($urandom % 2);
            wr   = 1'($urandom % 2);
            sa   = (($urandom % 4) == 0) ? int'($urandom % 9) : -1;
            if (is_page(code, itl, swr, wr)) sa = int'($urandom % 300);
            run(st, code, itl, swr, wr, sa);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule